// File: doc/BRIEF.md
# Byte-Addressed Little-Endian Memory Port

This block is a memory port over a 20-bit byte address space. Storage is organised as individual bytes. A request names an access size (byte, word of two bytes, or double word of four bytes) and any start address, odd or even. The port moves one byte per clock over an 8-bit internal path. A word therefore takes two transfer cycles and a double word four, always stepping upward from the start address. Multi-byte values are little-endian: the least significant byte sits at the lowest address.

For each access the port reports whether it is aligned. On reads it assembles the bytes into a 32-bit result and pulses a one-cycle done strobe after the last byte moves. A double word read is also presented split into its two halves as a far pointer. The lower word is the offset and the upper word is the segment base. The physical storage is a parameterised byte array, indexed by the low address bits, so it can stay small in simulation. An access running past the top of the address space continues at address zero.

Top module: `byte_mem_port`

## Requirements
- R1: After reset, busy, done and aligned are 0 and rdata is all zeros.
- R2: A byte read (size code 0) returns the stored byte in rdata[7:0] with rdata[31:8] zero. Each address holds exactly one independent byte.
- R3: A word write (size code 1) stores wdata[7:0] at the start address and wdata[15:8] at the next address. A word read returns them in the same lanes, with rdata[31:16] zero.
- R4: With start sampled high on an idle clock edge, busy rises and done is high after exactly 1, 2 or 4 further edges for byte, word or double word. Bytes move in increasing address order.
- R5: done is high for a single cycle, and busy is low whenever done is high. A new start is accepted on the edge at which done is high.
- R6: aligned is 1 for every byte access. For word and double word accesses it is 1 exactly when address bit 0 is 0. It is valid from the cycle after acceptance until the next accepted request.
- R7: A double word (size code 2) covers four consecutive bytes, least significant first. On a read, ptrOffset equals the bytes at the start address and the next address, and ptrSegment equals the following two bytes.
- R8: Byte addresses advance modulo 2^20, so a byte following address 0xFFFFF goes to address 0x00000.
- R9: start, size, addr, writeEn and wdata have no effect while busy is high. The access in progress completes unchanged, and no second access is performed.
- R10: Size code 3 behaves the same as size code 2.
- R11: A write leaves rdata at zero. rdata keeps a completed read result until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| writeEn | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 word, 2 or 3 double word |
| addr | input | 20 | Start byte address |
| wdata | input | 32 | Write data, lane 0 is the lowest address |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| aligned | output | 1 | Alignment of the current or last access |
| rdata | output | 32 | Assembled read data |
| ptrOffset | output | 16 | Offset half of a double word read |
| ptrSegment | output | 16 | Segment half of a double word read |

## Verification
The embedded properties assume that requests arrive only as single start pulses. They also assume that the request fields are held steady only at the accepting edge, and that the storage is never read before it has been written. The bench drives start for exactly one idle edge per request and reads only locations it has written earlier. The one exception is a deliberate burst of start while busy, used to show that such requests are ignored. The wrap case writes just below 0xFFFFF and reads back at 0x00000 and 0x00001, which fall on storage indices distinct from every other vector.

// File: rtl/memport_pkg.sv
package memport_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } accSize_e;

  typedef struct packed {
    logic       load;
    logic       xfer;
    logic [1:0] lane;
  } ctrlStrobe_t;

  function automatic logic [1:0] lastLaneOf(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lastLaneOf = 2'd0;
      SZ_WORD: lastLaneOf = 2'd1;
      default: lastLaneOf = 2'd3;
    endcase
  endfunction

  function automatic logic alignedOf(input logic [1:0] sz, input logic lowBit);
    alignedOf = (sz == SZ_BYTE) ? 1'b1 : ~lowBit;
  endfunction

endpackage

// File: rtl/memport_ctrl.sv
module memport_ctrl
  import memport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  size,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  typedef enum logic {ST_IDLE, ST_XFER} state_e;

  state_e     state;
  logic [1:0] laneCnt;
  logic [1:0] lastLane;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      laneCnt  <= 2'd0;
      lastLane <= 2'd0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_XFER;
            laneCnt  <= 2'd0;
            lastLane <= lastLaneOf(size);
          end
        end
        default: begin
          if (laneCnt == lastLane) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            laneCnt <= laneCnt + 2'd1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.xfer = (state == ST_XFER);
    strobe.lane = laneCnt;
    busy        = (state == ST_XFER);
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_lane_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (laneCnt <= lastLane));

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(lastLane));

  assert_lane_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(rstN)) |-> (laneCnt == $past(laneCnt) + 2'd1));

endmodule

// File: rtl/memport_datapath.sv
module memport_datapath
  import memport_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MEM_DEPTH = 256
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              writeEn,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              aligned
);

  localparam int IDX_W = $clog2(MEM_DEPTH);
  localparam int LANES = 4;

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] curAddr;
  logic [IDX_W-1:0]  memIdx;
  logic [31:0]       wBuf;
  logic              isWrite;
  logic              alignedQ;
  logic [7:0]        wByte;
  logic [7:0]        rByte;
  logic [7:0]        storage [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      wBuf     <= '0;
      isWrite  <= 1'b0;
      alignedQ <= 1'b0;
    end else if (strobe.load) begin
      baseAddr <= addr;
      wBuf     <= wdata;
      isWrite  <= writeEn;
      alignedQ <= alignedOf(size, addr[0]);
    end
  end

  always_comb begin
    curAddr = baseAddr + ADDR_W'(strobe.lane);
    memIdx  = curAddr[IDX_W-1:0];
    case (strobe.lane)
      2'd0:    wByte = wBuf[7:0];
      2'd1:    wByte = wBuf[15:8];
      2'd2:    wByte = wBuf[23:16];
      default: wByte = wBuf[31:24];
    endcase
    rByte = storage[memIdx];
  end

  always_ff @(posedge clk) begin
    if (strobe.xfer && isWrite) begin
      storage[memIdx] <= wByte;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdata[g*8 +: 8] <= 8'h00;
      end else if (strobe.load) begin
        rdata[g*8 +: 8] <= 8'h00;
      end else if (strobe.xfer && !isWrite && (strobe.lane == 2'(g))) begin
        rdata[g*8 +: 8] <= rByte;
      end
    end
  end

  assign aligned = alignedQ;

  assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |=> $stable(baseAddr));

  assert_byte_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && size == SZ_BYTE) |=> aligned);

  assert_odd_misaligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && size != SZ_BYTE && addr[0]) |=> !aligned);

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xfer && baseAddr == '1 && strobe.lane == 2'd1) |-> (curAddr == '0));

  assert_write_no_rdata_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xfer && isWrite) |=> (rdata == 32'h0));

endmodule

// File: rtl/byte_mem_port.sv
module byte_mem_port
  import memport_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MEM_DEPTH = 256
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              writeEn,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              busy,
  output logic              done,
  output logic              aligned,
  output logic [31:0]       rdata,
  output logic [15:0]       ptrOffset,
  output logic [15:0]       ptrSegment
);

  ctrlStrobe_t strobe;

  memport_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .size   (size),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  memport_datapath #(
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (MEM_DEPTH)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .writeEn (writeEn),
    .size    (size),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .aligned (aligned)
  );

  assign ptrOffset  = rdata[15:0];
  assign ptrSegment = rdata[31:16];

endmodule

// File: tb/byte_mem_port_test.sv
`timescale 1ns/1ps
module byte_mem_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        writeEn = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        busy, done, aligned;
  logic [31:0] rdata;
  logic [15:0] ptrOffset, ptrSegment;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  byte_mem_port uut (
    .clk(clk), .rstN(rstN), .start(start), .writeEn(writeEn), .size(size),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .aligned(aligned),
    .rdata(rdata), .ptrOffset(ptrOffset), .ptrSegment(ptrSegment)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [19:0] ad;
    logic [31:0] wd;
    logic [31:0] ex;
    logic        al;
    logic [2:0]  cyc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 20'h00008, 32'hA00055FF, 32'h0,        1'b1, 3'd4},
    '{1'b0, 2'd0, 20'h00008, 32'h0,        32'h000000FF, 1'b1, 3'd1},
    '{1'b0, 2'd0, 20'h00009, 32'h0,        32'h00000055, 1'b1, 3'd1},
    '{1'b0, 2'd0, 20'h0000A, 32'h0,        32'h00000000, 1'b1, 3'd1},
    '{1'b0, 2'd0, 20'h0000B, 32'h0,        32'h000000A0, 1'b1, 3'd1},
    '{1'b0, 2'd2, 20'h00008, 32'h0,        32'hA00055FF, 1'b1, 3'd4},
    '{1'b1, 2'd1, 20'h0072B, 32'h1234FDAA, 32'h0,        1'b0, 3'd2},
    '{1'b0, 2'd0, 20'h0072B, 32'h0,        32'h000000AA, 1'b1, 3'd1},
    '{1'b0, 2'd0, 20'h0072C, 32'h0,        32'h000000FD, 1'b1, 3'd1},
    '{1'b0, 2'd1, 20'h0072B, 32'h0,        32'h0000FDAA, 1'b0, 3'd2},
    '{1'b1, 2'd0, 20'h00110, 32'h12345691, 32'h0,        1'b1, 3'd1},
    '{1'b0, 2'd0, 20'h00110, 32'h0,        32'h00000091, 1'b1, 3'd1},
    '{1'b0, 2'd1, 20'h00008, 32'h0,        32'h000055FF, 1'b1, 3'd2},
    '{1'b1, 2'd3, 20'h00041, 32'h11223344, 32'h0,        1'b0, 3'd4},
    '{1'b0, 2'd3, 20'h00041, 32'h0,        32'h11223344, 1'b0, 3'd4},
    '{1'b0, 2'd0, 20'h00042, 32'h0,        32'h00000033, 1'b1, 3'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request for a single idle edge; return result and edge count to done.
  task automatic access(input logic wr, input logic [1:0] sz, input logic [19:0] ad,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic al, output int cyc);
    @(negedge clk);
    start = 1'b1; writeEn = wr; size = sz; addr = ad; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
    end
    rd = rdata;
    al = aligned;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic al;
    int cyc;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && aligned == 0, "R1 reset flags", {29'b0, busy, done, aligned}, 32'h0);
    check(rdata == 32'h0, "R1 reset rdata", rdata, 32'h0);
    rstN = 1'b1;

    // Vector table covering R2, R3, R4, R6, R7, R10, R11
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].sz, VECS[i].ad, VECS[i].wd, rd, al, cyc);
      check(rd == VECS[i].ex, "R2/R3/R7/R10/R11 data", rd, VECS[i].ex);
      check(al == VECS[i].al, "R6 aligned", {31'b0, al}, {31'b0, VECS[i].al});
      check(cyc == int'(VECS[i].cyc), "R4 cycles", cyc, {29'b0, VECS[i].cyc});
    end

    // R7: pointer halves
    access(1'b0, 2'd2, 20'h00008, 32'h0, rd, al, cyc);
    check(ptrOffset == 16'h55FF, "R7 offset", {16'h0, ptrOffset}, 32'h55FF);
    check(ptrSegment == 16'hA000, "R7 segment", {16'h0, ptrSegment}, 32'hA000);

    // R5: done lasts one cycle; busy low meanwhile
    check(done == 1 && busy == 0, "R5 done with idle", {30'b0, done, busy}, 32'h2);
    @(negedge clk);
    check(done == 0, "R5 done single cycle", {31'b0, done}, 32'h0);
    // R11: rdata held after completion
    check(rdata == 32'hA00055FF, "R11 rdata held", rdata, 32'hA00055FF);

    // R8: wrap across the top of the address space
    access(1'b1, 2'd2, 20'hFFFFE, 32'hCAFEBABE, rd, al, cyc);
    access(1'b0, 2'd0, 20'h00000, 32'h0, rd, al, cyc);
    check(rd == 32'hFE, "R8 wrap byte 2", rd, 32'hFE);
    access(1'b0, 2'd0, 20'h00001, 32'h0, rd, al, cyc);
    check(rd == 32'hCA, "R8 wrap byte 3", rd, 32'hCA);
    access(1'b0, 2'd0, 20'hFFFFF, 32'h0, rd, al, cyc);
    check(rd == 32'hBA, "R8 byte below top", rd, 32'hBA);

    // R9: start while busy is ignored
    access(1'b1, 2'd0, 20'h00060, 32'h00000000, rd, al, cyc);
    @(negedge clk);
    start = 1'b1; writeEn = 1'b1; size = 2'd2; addr = 20'h00050; wdata = 32'h89ABCDEF;
    @(posedge clk);
    @(negedge clk);
    writeEn = 1'b1; size = 2'd0; addr = 20'h00060; wdata = 32'h00000077;
    repeat (2) @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    for (int k = 0; k < 20; k++) begin
      if (done) break;
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    check(cyc == 4, "R9 in-flight access timing", cyc, 32'd4);
    @(negedge clk);
    check(busy == 0, "R9 no second access", {31'b0, busy}, 32'h0);
    access(1'b0, 2'd2, 20'h00050, 32'h0, rd, al, cyc);
    check(rd == 32'h89ABCDEF, "R9 in-flight data", rd, 32'h89ABCDEF);
    access(1'b0, 2'd0, 20'h00060, 32'h0, rd, al, cyc);
    check(rd == 32'h0, "R9 intruding write ignored", rd, 32'h0);

    // R5: back-to-back accepted on the done edge
    access(1'b0, 2'd0, 20'h00050, 32'h0, rd, al, cyc);
    start = 1'b1; writeEn = 1'b0; size = 2'd0; addr = 20'h00051;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1, "R5 accept on done edge", {31'b0, busy}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    check(done == 1 && rdata == 32'hCD, "R5 back-to-back result", rdata, 32'hCD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule